// File: doc/BRIEF.md
# Streaming Trapezoidal Area Integrator

This block estimates the area under a curve that arrives as a stream of unsigned samples, at most one per clock and qualified by a valid strobe. The horizontal step between two neighbouring samples counts as one unit. Each neighbouring pair adds a trapezoid to a running total. The trapezoid is split into a rectangle, whose height is the lower of the two samples, and a triangle, whose height is half the absolute gap between them. The half is formed with a one-bit right shift, so the datapath uses one compare and one subtract and has no multiplier or divider. Downstream logic multiplies the total by the real sample period.

A start pulse zeroes the total and arms the block. The first accepted sample after that only sets the stored previous value. Every later accepted sample adds one trapezoid. A clear pulse zeroes the total and disarms the block. The total is wider than the sample by a count parameter. When it would pass full scale it pins at full scale and raises a sticky flag. An alternative rising mode is for inputs that never decrease. In that mode the increment is formed as the previous sample plus half the forward step, which needs no compare.

Top module: `trap_area_integ`

## Requirements
- R1: After the synchronous reset `rst` or a `clear` pulse, `acc_total` reads 0 and `acc_sat` reads 0, and the block is disarmed.
- R2: After a start, the first accepted sample only sets the stored previous value. It leaves `acc_total` unchanged.
- R3: Each later accepted sample `s`, with stored previous value `p`, adds `min(s,p) + (|s-p| >> 1)` to `acc_total`. The shift truncates, so an odd gap loses its half unit. The sum is visible on the clock after the sample.
- R4: While `in_valid` is 0, `acc_total` and the stored previous value both hold. The next accepted sample pairs with the last accepted one.
- R5: `clear` takes priority over `start` and over a valid sample in the same cycle. `start` takes priority over a valid sample in the same cycle, and that sample is dropped.
- R6: While disarmed (after reset or clear and before a start), valid samples are ignored and `acc_total` stays 0.
- R7: If an addition would exceed full scale, `acc_total` pins at all ones and `acc_sat` goes to 1. `acc_sat` stays at 1 until a clear, start or reset.
- R8: With `rising_mode` at 1 and a non-decreasing input, the increment is `p + ((s-p) >> 1)`. This gives the same totals as R3.
- R9: `acc_total` is SAMPLE_W+COUNT_W bits wide. With the defaults (8 and 8), full scale is 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Zeroes the total and disarms |
| start | input | 1 | Zeroes the total and arms; the next sample primes |
| rising_mode | input | 1 | 1 selects the compare-free increment for non-decreasing input |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | SAMPLE_W | Unsigned sample |
| acc_total | output | SAMPLE_W+COUNT_W | Registered running area |
| acc_sat | output | 1 | Sticky saturation flag |

## Verification
The bench targets the following corner cases:
- **Priming sample.** A design that adds the first sample after a start would be off by that sample for the whole run.
- **Odd gaps.** A design that rounds the half-difference up, or takes the larger sample as the rectangle, drifts from the model by one or more units per pair.
- **Strobe gaps with a changing input.** These expose a previous-value register that follows the raw input instead of holding.
- **Simultaneous clear, start and valid.** These test the priority order.
- **A long full-scale run.** This forces the carry out of the total. A design that wraps instead of pinning, or that drops the flag, fails at once.

// File: rtl/trap_area_pkg.sv
package trap_area_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRIME = 2'd1,
    ST_RUN   = 2'd2
  } integ_state_e;
endpackage

// File: rtl/trap_increment.sv
// Per-pair area increment: lower sample plus half the gap (truncated).
module trap_increment #(
  parameter int SAMPLE_W = 8
) (
  input  logic [SAMPLE_W-1:0] cur_i,
  input  logic [SAMPLE_W-1:0] prev_i,
  input  logic                rising_i,
  output logic [SAMPLE_W-1:0] inc_o
);
  logic                cur_ge;
  logic [SAMPLE_W-1:0] lo;
  logic [SAMPLE_W-1:0] hi;
  logic [SAMPLE_W-1:0] span;
  logic [SAMPLE_W-1:0] fwd_span;

  always_comb begin
    cur_ge   = (cur_i >= prev_i);
    lo       = cur_ge ? prev_i : cur_i;
    hi       = cur_ge ? cur_i : prev_i;
    span     = hi - lo;
    fwd_span = cur_i - prev_i;
    if (rising_i) begin
      inc_o = prev_i + (fwd_span >> 1);
    end else begin
      inc_o = lo + (span >> 1);
    end
  end
endmodule

// File: rtl/sat_accum.sv
// Saturating accumulator with sticky full-scale flag.
module sat_accum #(
  parameter int ACC_W = 16,
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zero_i,
  input  logic             add_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             sat_o
);
  localparam logic [ACC_W-1:0] FULL = '1;
  localparam int PAD_W = ACC_W + 1 - INC_W;

  logic [ACC_W:0] sum;

  assign sum = {1'b0, acc_o} + {{PAD_W{1'b0}}, inc_i};

  always_ff @(posedge clk) begin
    if (rst || zero_i) begin
      acc_o <= '0;
      sat_o <= 1'b0;
    end else if (add_i) begin
      if (sum[ACC_W]) begin
        acc_o <= FULL;
        sat_o <= 1'b1;
      end else begin
        acc_o <= sum[ACC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/trap_area_integ.sv
module trap_area_integ
  import trap_area_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int COUNT_W  = 8,
  localparam int ACC_W   = SAMPLE_W + COUNT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                start,
  input  logic                rising_mode,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic [ACC_W-1:0]    acc_total,
  output logic                acc_sat
);
  integ_state_e        state_q;
  logic [SAMPLE_W-1:0] prev_q;
  logic [SAMPLE_W-1:0] step_inc;
  logic                take;
  logic                add_en;
  logic                zero_req;

  assign zero_req = clear | start;
  assign take     = in_valid & ~zero_req & (state_q != ST_IDLE);
  assign add_en   = take & (state_q == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state_q <= ST_IDLE;
    end else if (start) begin
      state_q <= ST_PRIME;
    end else if (take && state_q == ST_PRIME) begin
      state_q <= ST_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
    end else if (take) begin
      prev_q <= in_sample;
    end
  end

  trap_increment #(.SAMPLE_W(SAMPLE_W)) u_inc (
    .cur_i    (in_sample),
    .prev_i   (prev_q),
    .rising_i (rising_mode),
    .inc_o    (step_inc)
  );

  sat_accum #(.ACC_W(ACC_W), .INC_W(SAMPLE_W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .zero_i (zero_req),
    .add_i  (add_en),
    .inc_i  (step_inc),
    .acc_o  (acc_total),
    .sat_o  (acc_sat)
  );
endmodule

// File: rtl/trap_area_integ_chk.sv
module trap_area_integ_chk #(
  parameter int SAMPLE_W = 8,
  parameter int COUNT_W  = 8,
  localparam int ACC_W   = SAMPLE_W + COUNT_W
) (
  input logic                clk,
  input logic                rst,
  input logic                clear,
  input logic                start,
  input logic                in_valid,
  input logic [ACC_W-1:0]    acc_total,
  input logic                acc_sat
);
  localparam logic [ACC_W:0]   MAX_INC = (ACC_W+1)'((1 << SAMPLE_W) - 1);
  localparam logic [ACC_W-1:0] FULL    = '1;

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (acc_total == '0) && !acc_sat);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !clear && !start) |=> $stable(acc_total));

  // R3
  step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear && !start) |=>
      (({1'b0, acc_total} - {1'b0, $past(acc_total)}) <= MAX_INC));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    acc_sat |-> (acc_total == FULL));

  // R7
  sat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_sat && !clear && !start) |=> acc_sat);
endmodule

bind trap_area_integ trap_area_integ_chk #(
  .SAMPLE_W(SAMPLE_W),
  .COUNT_W (COUNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clear     (clear),
  .start     (start),
  .in_valid  (in_valid),
  .acc_total (acc_total),
  .acc_sat   (acc_sat)
);

// File: tb/sim_trap_area_integ.sv
`timescale 1ns/1ps
module sim_trap_area_integ;
  localparam int SW = 8;
  localparam int CW = 8;
  localparam int AW = SW + CW;
  localparam longint FULL = (longint'(1) << AW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clear = 1'b0;
  logic start = 1'b0;
  logic rising_mode = 1'b0;
  logic in_valid = 1'b0;
  logic [SW-1:0] in_sample = '0;
  logic [AW-1:0] acc_total;
  logic acc_sat;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string tag = "R1";

  longint m_acc = 0;
  bit     m_sat = 0;
  int     m_state = 0;
  int     m_prev = 0;
  int     a_s, lo_s, gap_s;

  trap_area_integ #(.SAMPLE_W(SW), .COUNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .clear(clear), .start(start),
    .rising_mode(rising_mode), .in_valid(in_valid), .in_sample(in_sample),
    .acc_total(acc_total), .acc_sat(acc_sat)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string t, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  // Behavioural reference, advanced on each edge, compared shortly after.
  always @(posedge clk) begin
    if (rst || clear) begin
      m_acc = 0; m_sat = 0; m_state = 0;
      if (rst) m_prev = 0;
    end else if (start) begin
      m_acc = 0; m_sat = 0; m_state = 1;
    end else if (in_valid && m_state != 0) begin
      a_s = int'(in_sample);
      if (m_state == 1) begin
        m_state = 2;
      end else begin
        lo_s  = (a_s < m_prev) ? a_s : m_prev;
        gap_s = (a_s > m_prev) ? a_s - m_prev : m_prev - a_s;
        m_acc = m_acc + lo_s + gap_s / 2;
        if (m_acc > FULL) begin
          m_acc = FULL; m_sat = 1;
        end
      end
      m_prev = a_s;
    end
    #1;
    if (!finished) begin
      chk(tag, longint'(acc_total), m_acc);
      chk(tag, longint'(acc_sat), longint'(m_sat));
    end
  end

  task automatic drive(input bit c, input bit st, input bit v, input int s);
    @(negedge clk);
    clear = c; start = st; in_valid = v; in_sample = s[SW-1:0];
  endtask

  task automatic expect_now(input string t, input longint e_acc, input bit e_sat);
    @(posedge clk);
    #2;
    chk(t, longint'(acc_total), e_acc);
    chk(t, longint'(acc_sat), longint'(e_sat));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    drive(0, 0, 1, 50);
    drive(0, 0, 1, 51);
    expect_now("R1", 0, 0);
    @(negedge clk); rst = 1'b0;
    tag = "R6";
    drive(0, 0, 1, 40);
    drive(0, 0, 1, 60);
    expect_now("R6", 0, 0);

    tag = "R5";
    drive(0, 1, 1, 99);               // start drops this sample
    tag = "R2";
    drive(0, 0, 1, 10);
    expect_now("R2", 0, 0);
    tag = "R3";
    drive(0, 0, 1, 20);
    expect_now("R3", 15, 0);
    drive(0, 0, 1, 13);
    expect_now("R3", 31, 0);

    tag = "R4";
    drive(0, 0, 0, 200);
    drive(0, 0, 0, 201);
    expect_now("R4", 31, 0);
    drive(0, 0, 1, 13);
    expect_now("R4", 44, 0);

    tag = "R5";
    drive(1, 1, 1, 250);
    expect_now("R5", 0, 0);
    drive(0, 0, 1, 30);
    expect_now("R5", 0, 0);
    drive(0, 1, 0, 0);
    drive(0, 0, 1, 7);
    drive(0, 0, 1, 8);
    expect_now("R3", 7, 0);

    tag = "R3";
    for (int i = 0; i < 300; i++) begin
      drive(0, 0, ($urandom % 4) != 0, int'($urandom % 256));
    end

    tag = "R8";
    drive(1, 0, 0, 0);
    drive(0, 1, 0, 0);
    @(negedge clk); rising_mode = 1'b1;
    begin
      int ramp[7] = '{0, 3, 4, 9, 9, 20, 255};
      foreach (ramp[k]) drive(0, 0, 1, ramp[k]);
    end
    expect_now("R8", 170, 0);
    @(negedge clk); rising_mode = 1'b0;

    tag = "R7";
    drive(1, 0, 0, 0);
    drive(0, 1, 0, 0);
    for (int i = 0; i < 300; i++) drive(0, 0, 1, 255);
    expect_now("R9", 65535, 1);
    drive(0, 0, 0, 0);
    expect_now("R7", 65535, 1);
    drive(0, 1, 0, 0);
    expect_now("R7", 0, 0);
    tag = "R1";
    drive(1, 0, 1, 5);
    expect_now("R1", 0, 0);
    drive(0, 0, 0, 0);
    @(negedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule